// File: doc/BRIEF.md
# DMA Software Request Front End

This block sits in front of the per-channel transfer engines of a multi-channel DMA controller and lets software start transactions by writing request bits. Two request registers hold pending work: one for chunk transactions and one for single transactions. In each, channel x owns an interleaved bit pair. Bit 2x is the source side and bit 2x+1 is the destination side. A bit that software sets is presented to the engine as a level. The bit stays up until the engine returns a completion pulse for it, and then the hardware clears it.

A select register chooses, per channel and per direction, whether the engine sees the software bit or a dedicated hardware request line. Software finds out that a transaction has finished by reading back the chunk and single registers until both of the channel's bits read zero. A last-transaction register is passed to the engine only for directions where the peripheral acts as flow controller. For every other direction it is masked off.

Register addresses are 0 for chunk, 1 for single, 2 for select and 3 for last. Writes to addresses 0 and 1 can only set bits. Writes to addresses 2 and 3 replace the low 2·NCH bits.

Top module: `dma_swreq_unit`

## Requirements
- R1: Writing 1 to bit 2x (source) or 2x+1 (destination) at address 0 sets the chunk request bit of channel x. From the next cycle that bit drives chunk_req_o, as long as the direction is in software mode.
- R2: Writing 1 to bit 2x or 2x+1 at address 1 sets the single request bit in the same way, and that bit drives single_req_o.
- R3: Writing 0 to a request bit has no effect. A bit that is already set stays set until its completion pulse, even if it is written with 1 again.
- R4: A completion pulse on chunk_done_i or single_done_i bit n clears request bit n at the next clock edge. Once a transaction has finished, both of its bits read 0.
- R5: If a completion pulse and a write of 1 hit the same bit in the same cycle, the bit ends up cleared and the write is lost.
- R6: Select bit n at address 2 chooses the request source for that direction: 0 selects software handshaking and 1 selects hardware handshaking. With 1, writes of 1 to request bit n are ignored (the bit reads back unchanged), and the request output follows the hardware request input bit n.
- R7: last_o bit n equals bit n of the last-transaction register (address 3) when periph_fc_i bit n is 1. Otherwise last_o bit n is 0.
- R8: rd_data returns the register selected by rd_addr (0 chunk, 1 single, 2 select, 3 last) in bits 2·NCH-1:0. All bits above these read as zero.
- R9: After reset, all registers read 0 and all request and last outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | DW | Read data |
| hw_chunk_req_i | input | 2·NCH | Hardware chunk request lines |
| hw_single_req_i | input | 2·NCH | Hardware single request lines |
| chunk_done_i | input | 2·NCH | Chunk completion pulses from the engine |
| single_done_i | input | 2·NCH | Single completion pulses from the engine |
| periph_fc_i | input | 2·NCH | Peripheral is the flow controller for this direction |
| chunk_req_o | output | 2·NCH | Chunk request levels to the engine |
| single_req_o | output | 2·NCH | Single request levels to the engine |
| last_o | output | 2·NCH | Last-transaction flags to the engine |

## Verification
Random cycles mix set-only writes, sparse completion pulses, random hardware request lines and occasional changes to the select register. This exposes set-versus-clear ordering errors and mixing up the two request registers. A directed cycle that writes 0 separates set-only behaviour from a plain overwrite. A write and a completion on the same bit shows which of the two wins. A write to a hardware-mode bit, checked through readback, shows whether the select gates the write path or only the output mux. A last-register pattern paired with a partial flow-control mask shows that the masking is done per direction.

// File: rtl/dma_swreq_unit.sv
module dma_swreq_unit #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [2*NCH-1:0] hw_chunk_req_i,
  input  logic [2*NCH-1:0] hw_single_req_i,
  input  logic [2*NCH-1:0] chunk_done_i,
  input  logic [2*NCH-1:0] single_done_i,
  input  logic [2*NCH-1:0] periph_fc_i,
  output logic [2*NCH-1:0] chunk_req_o,
  output logic [2*NCH-1:0] single_req_o,
  output logic [2*NCH-1:0] last_o
);
  localparam int RW = 2 * NCH;

  logic [RW-1:0] chk_q, sgl_q, sel_q, lst_q;
  logic [RW-1:0] wbits;

  assign wbits = wr_data[RW-1:0];

  wire wr_chk = wr_en && (wr_addr == 2'd0);
  wire wr_sgl = wr_en && (wr_addr == 2'd1);
  wire wr_sel = wr_en && (wr_addr == 2'd2);
  wire wr_lst = wr_en && (wr_addr == 2'd3);

  wire [RW-1:0] chk_set = wr_chk ? (wbits & ~sel_q) : '0;
  wire [RW-1:0] sgl_set = wr_sgl ? (wbits & ~sel_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= '0;
      sgl_q <= '0;
      sel_q <= '0;
      lst_q <= '0;
    end else begin
      chk_q <= (chk_q | chk_set) & ~chunk_done_i;
      sgl_q <= (sgl_q | sgl_set) & ~single_done_i;
      if (wr_sel) sel_q <= wbits;
      if (wr_lst) lst_q <= wbits;
    end
  end

  assign chunk_req_o  = (chk_q & ~sel_q) | (hw_chunk_req_i & sel_q);
  assign single_req_o = (sgl_q & ~sel_q) | (hw_single_req_i & sel_q);
  assign last_o       = lst_q & periph_fc_i;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: rd_data[RW-1:0] = chk_q;
      2'd1: rd_data[RW-1:0] = sgl_q;
      2'd2: rd_data[RW-1:0] = sel_q;
      default: rd_data[RW-1:0] = lst_q;
    endcase
  end
endmodule

// File: rtl/dma_swreq_chk.sv
module dma_swreq_chk #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NCH-1:0]  chunk_done_i,
  input logic [2*NCH-1:0]  single_done_i,
  input logic [2*NCH-1:0]  chk_q,
  input logic [2*NCH-1:0]  sgl_q,
  input logic [2*NCH-1:0]  sel_q,
  input logic [DW-1:0]     rd_data
);
  localparam int RW = 2 * NCH;

  // R4 and R5: a completion always leaves its bit cleared
  a_r4_chunk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|chunk_done_i) |=> ((chk_q & $past(chunk_done_i)) == '0));
  a_r4_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|single_done_i) |=> ((sgl_q & $past(single_done_i)) == '0));

  a_r3_chunk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(chk_q) & ~$past(chunk_done_i) & ~chk_q) == '0));
  a_r3_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sgl_q) & ~$past(single_done_i) & ~sgl_q) == '0));

  a_r6_hw_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((chk_q & ~$past(chk_q)) | (sgl_q & ~$past(sgl_q))) & $past(sel_q)) == '0));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> RW) == '0);
endmodule

bind dma_swreq_unit dma_swreq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chunk_done_i(chunk_done_i), .single_done_i(single_done_i),
  .chk_q(chk_q), .sgl_q(sgl_q), .sel_q(sel_q), .rd_data(rd_data));

// File: tb/sim_dma_swreq_unit.sv
module sim_dma_swreq_unit;
  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int RW  = 2 * NCH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [RW-1:0] hw_c = '0, hw_s = '0, dn_c = '0, dn_s = '0, fc = '0;
  logic [RW-1:0] creq, sreq, lst;

  int checks = 0, errors = 0, cycles = 0;
  logic [RW-1:0] m_chk = '0, m_sgl = '0, m_sel = '0, m_lst = '0;

  always #10 clk = ~clk;

  dma_swreq_unit #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .hw_chunk_req_i(hw_c), .hw_single_req_i(hw_s),
    .chunk_done_i(dn_c), .single_done_i(dn_s), .periph_fc_i(fc),
    .chunk_req_o(creq), .single_req_o(sreq), .last_o(lst));

  function automatic logic [RW-1:0] nxt_req(logic [RW-1:0] q, logic hit, logic [RW-1:0] d,
                                            logic [RW-1:0] sel, logic [RW-1:0] done);
    return (q | (hit ? (d & ~sel) : '0)) & ~done;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [1:0] a);
    logic [DW-1:0] r = '0;
    case (a)
      2'd0: r[RW-1:0] = m_chk;
      2'd1: r[RW-1:0] = m_sgl;
      2'd2: r[RW-1:0] = m_sel;
      default: r[RW-1:0] = m_lst;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R1 chunk_req_o"}, DW'(creq), DW'((m_chk & ~m_sel) | (hw_c & m_sel)));
    check({tag, " R2 single_req_o"}, DW'(sreq), DW'((m_sgl & ~m_sel) | (hw_s & m_sel)));
    check({tag, " R7 last_o"}, DW'(lst), DW'(m_lst & fc));
    check({tag, " R8 rd_data"}, rd_data, exp_rd(rd_addr));
  endtask

  task automatic tick(string tag);
    logic [RW-1:0] nc, ns, nsel, nl;
    nc   = nxt_req(m_chk, wr_en && wr_addr == 2'd0, wr_data[RW-1:0], m_sel, dn_c);
    ns   = nxt_req(m_sgl, wr_en && wr_addr == 2'd1, wr_data[RW-1:0], m_sel, dn_s);
    nsel = (wr_en && wr_addr == 2'd2) ? wr_data[RW-1:0] : m_sel;
    nl   = (wr_en && wr_addr == 2'd3) ? wr_data[RW-1:0] : m_lst;
    @(posedge clk);
    m_chk = nc; m_sgl = ns; m_sel = nsel; m_lst = nl;
    @(negedge clk);
    wr_en = 1'b0; dn_c = '0; dn_s = '0;
    check_all(tag);
  endtask

  task automatic wr(logic [1:0] a, logic [RW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 check("R9 reset rd_data", rd_data, '0);
    end
    check("R9 reset outputs", DW'({creq | sreq | lst}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R2: set source of ch0 and destination of ch3
    rd_addr = 2'd0; wr(2'd0, 16'h0081); tick("dir");
    rd_addr = 2'd1; wr(2'd1, 16'h0003); tick("dir");
    // R3: a write of 0 leaves both bits standing
    rd_addr = 2'd0; wr(2'd0, 16'h0000); tick("R3 zero write");
    check("R3 zero write keeps", rd_data, 32'h0081);
    // R4: completion on bit 0 only
    dn_c = 16'h0001; tick("R4 clear");
    check("R4 clear bit0", rd_data, 32'h0080);
    // R5: write and completion on bit 5 in the same cycle
    wr(2'd0, 16'h0020); dn_c = 16'h0020; tick("R5 collide");
    check("R5 collide dropped", rd_data, 32'h0080);
    // R6: ch1 source in hardware mode ignores writes
    wr(2'd2, 16'h0004); tick("R6 sel");
    hw_c = 16'h0004; wr(2'd0, 16'h0004); tick("R6 ignore");
    check("R6 write ignored", rd_data, 32'h0080);
    check("R6 hw passthrough", DW'(creq), 32'h0084);
    // R7: last register only where flow control is set
    rd_addr = 2'd3; fc = 16'h00F0; wr(2'd3, 16'h0FF0); tick("R7 last");
    check("R7 masked last", DW'(lst), 32'h00F0);
    wr(2'd2, 16'h0000); tick("restore");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(1, 0) == 1) begin
        if ($urandom_range(9, 0) == 0) wr(2'd2, RW'($urandom & $urandom));
        else wr(2'($urandom_range(3, 0)), RW'($urandom));
      end
      dn_c = RW'($urandom & $urandom & $urandom);
      dn_s = RW'($urandom & $urandom & $urandom);
      hw_c = RW'($urandom); hw_s = RW'($urandom); fc = RW'($urandom);
      rd_addr = 2'($urandom_range(3, 0));
      tick("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule